// File: doc/BRIEF.md
# DPLL Mode and Lock Controller

This block models the control and status side of a digital PLL. Software sees three registers through a simple write port and a combinational read port. The mode register carries a lock or bypass request. The configuration register holds a multiplier, a divider and a bypass-select bit. The status register reports a locked flag and a bypass flag. The analog loop itself is not modelled. Lock acquisition is a cycle-count timer, and leaving lock goes through a timed transition before the bypass flag is raised.

The expected software sequence has four steps:
1. Request bypass.
2. Wait for the bypass flag.
3. Program the multiplier and divider.
4. Request lock and poll the locked flag with a bounded timeout.

The block also drives the effective output-to-reference frequency ratio. The output frequency is the multiplier times the reference divided by (divider field + 1). When the loop is not locked, the output follows the reference, so the ratio reads 1/1.

Top module: `dpll_lock_ctrl`

## Requirements
- R1: After reset the bypass flag is 1 and the locked flag is 0. The mode register reads 4, the configuration register reads 0, and the ratio outputs are 1/1 with the valid flag low.
- R2: The register map uses four addresses. Address 0 is the mode register, held in bits [2:0]. Address 1 is the configuration register: bit 23 is bypass select, bits [18:8] are the multiplier and bits [6:0] are the divider. Address 2 is the status register: bit 8 is the bypass flag and bit 0 is the locked flag. All other bits read 0. Writes to addresses 2 and 3 have no effect, and address 3 reads 0.
- R3: Mode code 7 requests lock. Take a lock request accepted in the bypass state with a lockable configuration, at clock edge E. The locked flag rises at edge E+LOCK_CYC. The bypass flag stays 1 until that same edge and falls there.
- R4: A configuration is lockable only when bypass select is 0 and the multiplier is at least 2. While mode 7 is held and the configuration is not lockable, the block stays in bypass. The lock timer then starts at the edge that accepts a lockable configuration.
- R5: The restart rule covers relocking or locked operation. A write that changes the multiplier or the divider drops the locked flag and raises the bypass flag at the accepting edge. It also restarts the full LOCK_CYC count. Rewriting identical values changes nothing.
- R6: A configuration write that makes the configuration unlockable during relocking or locked operation moves the block to bypass at the accepting edge.
- R7: Mode code 4 requests bypass. Accepted during relocking or locked operation, it clears both flags at edge E. The bypass flag is then raised at edge E+BYP_CYC. Mode 4 written while already in bypass changes nothing.
- R8: While bypass is being entered, mode and configuration writes do not alter its timing. If mode 7 is held when bypass is reached, relocking starts at the next edge.
- R9: While locked, the ratio outputs give the multiplier field and (divider field + 1), with the valid flag high. Otherwise they give 1 and 1 with the valid flag low.
- R10: Mode codes other than 4 and 7 are stored and read back, but they request nothing and leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| locked_o | output | 1 | Locked flag (status bit 0) |
| bypass_o | output | 1 | Bypass flag (status bit 8) |
| ratio_valid_o | output | 1 | Ratio outputs describe a locked loop |
| ratio_mult_o | output | 11 | Effective multiplier |
| ratio_div_o | output | 8 | Effective divider |

## Verification
The hardest situations to reach from the ports are writes that land inside a timed window. Examples are a divider change part-way through a relock count, or a lock request plus a multiplier change issued while bypass is still being entered. The stimulus reaches these by timing writes a fixed number of idle cycles after the request that opened the window. A behavioural model in the bench tracks the state, the timer and the registers on every edge, and all outputs and the rotating read port are compared against it each cycle.

// File: rtl/dpll_ctl_pkg.sv
package dpll_ctl_pkg;

    localparam int ADDR_W       = 2;
    localparam int DATA_W       = 32;
    localparam int MODE_W       = 3;
    localparam int MULT_W       = 11;
    localparam int DIV_W        = 7;
    localparam int MULT_LSB     = 8;
    localparam int DIV_LSB      = 0;
    localparam int CFG_BSEL_BIT = 23;
    localparam int ST_BYP_BIT   = 8;
    localparam int ST_LCK_BIT   = 0;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    localparam logic [MODE_W-1:0] MODE_BYP  = 3'd4;
    localparam logic [MODE_W-1:0] MODE_LOCK = 3'd7;

    typedef enum logic [1:0] {
        PST_BYPASS = 2'd0,
        PST_ENTER  = 2'd1,
        PST_RELOCK = 2'd2,
        PST_LOCKED = 2'd3
    } pll_st_e;

    typedef struct packed {
        logic              bsel;
        logic [MULT_W-1:0] mult;
        logic [DIV_W-1:0]  div;
    } pll_cfg_s;

    function automatic logic cfg_lockable(input pll_cfg_s c);
        return !c.bsel && (c.mult >= MULT_W'(2));
    endfunction

endpackage

// File: rtl/dpll_regs.sv
module dpll_regs
    import dpll_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [MODE_W-1:0] mode_q_o,
    output logic [MODE_W-1:0] mode_d_o,
    output pll_cfg_s          cfg_q_o,
    output pll_cfg_s          cfg_d_o,
    output logic              cfg_chg_o
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        pll_cfg_s          cfg;
    } regs_s;

    regs_s regs_d, regs_q;
    logic  chg_d;
    logic  unused_wr;

    assign unused_wr = ^{wr_data_i[31:24], wr_data_i[22:19], wr_data_i[7]};

    always_comb begin
        regs_d = regs_q;
        chg_d  = 1'b0;
        if (wr_en_i && wr_addr_i == ADDR_MODE) begin
            regs_d.mode = wr_data_i[MODE_W-1:0];
        end
        if (wr_en_i && wr_addr_i == ADDR_CFG) begin
            regs_d.cfg.bsel = wr_data_i[CFG_BSEL_BIT];
            regs_d.cfg.mult = wr_data_i[MULT_LSB +: MULT_W];
            regs_d.cfg.div  = wr_data_i[DIV_LSB +: DIV_W];
            chg_d = (regs_d.cfg.mult != regs_q.cfg.mult) ||
                    (regs_d.cfg.div  != regs_q.cfg.div);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.mode <= MODE_BYP;
            regs_q.cfg  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign mode_q_o  = regs_q.mode;
    assign mode_d_o  = regs_d.mode;
    assign cfg_q_o   = regs_q.cfg;
    assign cfg_d_o   = regs_d.cfg;
    assign cfg_chg_o = chg_d;

    AST_SAME_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_CFG && !cfg_chg_o) |=>
            ($stable(cfg_q_o.mult) && $stable(cfg_q_o.div))) else $error("same cfg"); // R5

endmodule

// File: rtl/dpll_seq.sv
module dpll_seq
    import dpll_ctl_pkg::*;
#(
    parameter int LOCK_CYC = 24,
    parameter int BYP_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_d_i,
    input  pll_cfg_s          cfg_d_i,
    input  logic              cfg_chg_i,
    output logic              locked_o,
    output logic              bypass_o
);

    localparam int MAXC  = (LOCK_CYC > BYP_CYC) ? LOCK_CYC : BYP_CYC;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] LOCK_INIT = CNT_W'(LOCK_CYC - 1);
    localparam logic [CNT_W-1:0] BYP_INIT  = CNT_W'(BYP_CYC - 1);

    typedef struct packed {
        pll_st_e          st;
        logic [CNT_W-1:0] cnt;
    } seq_s;

    seq_s seq_d, seq_q;
    logic lockable;

    assign lockable = cfg_lockable(cfg_d_i);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            PST_BYPASS: begin
                if (mode_d_i == MODE_LOCK && lockable) begin
                    seq_d.st  = PST_RELOCK;
                    seq_d.cnt = LOCK_INIT;
                end
            end
            PST_ENTER: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = PST_BYPASS;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                if (mode_d_i == MODE_BYP) begin
                    seq_d.st  = PST_ENTER;
                    seq_d.cnt = BYP_INIT;
                end else if (!lockable) begin
                    seq_d.st  = PST_BYPASS;
                    seq_d.cnt = '0;
                end else if (cfg_chg_i) begin
                    seq_d.st  = PST_RELOCK;
                    seq_d.cnt = LOCK_INIT;
                end else if (seq_q.st == PST_RELOCK) begin
                    if (seq_q.cnt == '0) begin
                        seq_d.st = PST_LOCKED;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= PST_BYPASS;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign locked_o = (seq_q.st == PST_LOCKED);
    assign bypass_o = (seq_q.st == PST_BYPASS) || (seq_q.st == PST_RELOCK);

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked_o && bypass_o)) else $error("flags both set"); // R3

    AST_LOCK_AFTER_BYP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(bypass_o)) else $error("lock not from bypass"); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(seq_q.cnt) < MAXC)) else $error("counter range"); // R3

    AST_CHG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && cfg_chg_i && mode_d_i != MODE_BYP) |=> !locked_o) else $error("chg kept lock"); // R5

    AST_BYPREQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && mode_d_i == MODE_BYP) |=> (!locked_o && !bypass_o)) else $error("bypass entry"); // R7

endmodule

// File: rtl/dpll_view.sv
module dpll_view
    import dpll_ctl_pkg::*;
(
    input  logic              locked_i,
    input  logic              bypass_i,
    input  logic [MODE_W-1:0] mode_q_i,
    input  pll_cfg_s          cfg_q_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ratio_valid_o,
    output logic [MULT_W-1:0] ratio_mult_o,
    output logic [DIV_W:0]    ratio_div_o
);

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_MODE: rd_data_o[MODE_W-1:0] = mode_q_i;
            ADDR_CFG: begin
                rd_data_o[CFG_BSEL_BIT]         = cfg_q_i.bsel;
                rd_data_o[MULT_LSB +: MULT_W]   = cfg_q_i.mult;
                rd_data_o[DIV_LSB +: DIV_W]     = cfg_q_i.div;
            end
            ADDR_STAT: begin
                rd_data_o[ST_BYP_BIT] = bypass_i;
                rd_data_o[ST_LCK_BIT] = locked_i;
            end
            default: rd_data_o = '0;
        endcase
    end

    always_comb begin
        ratio_valid_o = locked_i;
        if (locked_i) begin
            ratio_mult_o = cfg_q_i.mult;
            ratio_div_o  = {1'b0, cfg_q_i.div} + 1'b1;
        end else begin
            ratio_mult_o = MULT_W'(1);
            ratio_div_o  = (DIV_W+1)'(1);
        end
    end

endmodule

// File: rtl/dpll_lock_ctrl.sv
module dpll_lock_ctrl
    import dpll_ctl_pkg::*;
#(
    parameter int LOCK_CYC = 24,
    parameter int BYP_CYC  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        locked_o,
    output logic        bypass_o,
    output logic        ratio_valid_o,
    output logic [10:0] ratio_mult_o,
    output logic [7:0]  ratio_div_o
);

    logic [MODE_W-1:0] mode_q, mode_d;
    pll_cfg_s          cfg_q, cfg_d;
    logic              cfg_chg;

    dpll_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .mode_q_o  (mode_q),
        .mode_d_o  (mode_d),
        .cfg_q_o   (cfg_q),
        .cfg_d_o   (cfg_d),
        .cfg_chg_o (cfg_chg)
    );

    dpll_seq #(.LOCK_CYC(LOCK_CYC), .BYP_CYC(BYP_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_d_i  (mode_d),
        .cfg_d_i   (cfg_d),
        .cfg_chg_i (cfg_chg),
        .locked_o  (locked_o),
        .bypass_o  (bypass_o)
    );

    dpll_view u_view (
        .locked_i      (locked_o),
        .bypass_i      (bypass_o),
        .mode_q_i      (mode_q),
        .cfg_q_i       (cfg_q),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .ratio_valid_o (ratio_valid_o),
        .ratio_mult_o  (ratio_mult_o),
        .ratio_div_o   (ratio_div_o)
    );

    AST_LOCK_NEEDS_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (ratio_mult_o >= 11'd2 && !cfg_q.bsel)) else $error("unlockable cfg locked"); // R4

    AST_BYPSEL_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && cfg_d.bsel) |=> !locked_o) else $error("bypass select ignored"); // R6

endmodule

// File: tb/dpll_lock_ctrl_tb.sv
module dpll_lock_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOCK_N     = 12;
    localparam int BYP_N      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        locked_o, bypass_o, ratio_valid_o;
    logic [10:0] ratio_mult_o;
    logic [7:0]  ratio_div_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // reference model state: 0 bypass, 1 entering, 2 relock, 3 locked
    int         m_st, m_cnt;
    logic [2:0] m_mode;
    logic       m_bsel;
    logic [10:0] m_mult;
    logic [6:0]  m_div;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpll_lock_ctrl #(.LOCK_CYC(LOCK_N), .BYP_CYC(BYP_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .locked_o(locked_o), .bypass_o(bypass_o), .ratio_valid_o(ratio_valid_o),
        .ratio_mult_o(ratio_mult_o), .ratio_div_o(ratio_div_o)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_mode = 3'd4; m_bsel = 0; m_mult = 0; m_div = 0;
        end else begin
            logic [2:0]  nmode;
            logic        nb, chg, okc;
            logic [10:0] nm;
            logic [6:0]  nd;
            nmode = m_mode; nb = m_bsel; nm = m_mult; nd = m_div; chg = 0;
            if (wr_en && wr_addr == 2'd0) nmode = wr_data[2:0];
            if (wr_en && wr_addr == 2'd1) begin
                nb = wr_data[23]; nm = wr_data[18:8]; nd = wr_data[6:0];
                chg = (nm != m_mult) || (nd != m_div);
            end
            okc = !nb && (nm > 1);
            if (m_st == 0) begin
                if (nmode == 3'd7 && okc) begin m_st = 2; m_cnt = LOCK_N; end
            end else if (m_st == 1) begin
                m_cnt--;
                if (m_cnt == 0) m_st = 0;
            end else begin
                if (nmode == 3'd4) begin m_st = 1; m_cnt = BYP_N; end
                else if (!okc) m_st = 0;
                else if (chg) begin m_st = 2; m_cnt = LOCK_N; end
                else if (m_st == 2) begin
                    m_cnt--;
                    if (m_cnt == 0) m_st = 3;
                end
            end
            m_mode = nmode; m_bsel = nb; m_mult = nm; m_div = nd;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic        lk, by;
        logic [31:0] rexp;
        lk = (m_st == 3);
        by = (m_st == 0) || (m_st == 2);
        chk("locked", {31'd0, locked_o}, {31'd0, lk});
        chk("bypass", {31'd0, bypass_o}, {31'd0, by});
        chk("ratio_valid", {31'd0, ratio_valid_o}, {31'd0, lk});
        chk("ratio_mult", {21'd0, ratio_mult_o}, lk ? {21'd0, m_mult} : 32'd1);
        chk("ratio_div", {24'd0, ratio_div_o}, lk ? ({25'd0, m_div} + 32'd1) : 32'd1);
        case (rd_addr)
            2'd0: rexp = {29'd0, m_mode};
            2'd1: rexp = {8'd0, m_bsel, 4'd0, m_mult, 1'b0, m_div};
            2'd2: rexp = {23'd0, by, 7'd0, lk};
            default: rexp = 32'd0;
        endcase
        chk("rd_data", rd_data, rexp);
    endtask

    task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d, input string rq);
        @(negedge clk);
        compare_all();
        cur_req = rq;
        wr_en   = w;
        wr_addr = a;
        wr_data = d;
        rd_addr = rd_addr + 2'd1;
    endtask

    task automatic idle(input int n, input string rq);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, rq);
    endtask

    function automatic logic [31:0] cfgw(input logic b, input logic [10:0] m, input logic [6:0] dv);
        return {8'hA5, b, 4'hF, m, 1'b1, dv};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4, "R1");
        // R10: unused mode code in bypass
        step(1, 2'd0, 32'hFFFF_FFF3, "R10"); idle(3, "R10");
        step(1, 2'd0, 32'd4, "R7"); idle(2, "R7");
        // R4: lock request with unlockable configurations
        step(1, 2'd0, 32'd7, "R4"); idle(4, "R4");
        step(1, 2'd1, cfgw(1'b0, 11'd1, 7'd3), "R4"); idle(4, "R4");
        step(1, 2'd1, cfgw(1'b1, 11'd10, 7'd1), "R4"); idle(4, "R4");
        // R3: lockable config starts the count
        step(1, 2'd1, cfgw(1'b0, 11'd10, 7'd1), "R3"); idle(LOCK_N + 3, "R9");
        // R2: writes to status and spare address ignored
        step(1, 2'd2, 32'hFFFF_FFFF, "R2"); step(1, 2'd3, 32'hFFFF_FFFF, "R2"); idle(4, "R2");
        // R5: identical rewrite, then changes
        step(1, 2'd1, cfgw(1'b0, 11'd10, 7'd1), "R5"); idle(3, "R5");
        step(1, 2'd1, cfgw(1'b0, 11'd12, 7'd1), "R5"); idle(LOCK_N / 2, "R5");
        step(1, 2'd1, cfgw(1'b0, 11'd12, 7'd3), "R5"); idle(LOCK_N + 2, "R5");
        // R6: bypass select while locked, then clear it
        step(1, 2'd1, cfgw(1'b1, 11'd12, 7'd3), "R6"); idle(3, "R6");
        step(1, 2'd1, cfgw(1'b0, 11'd12, 7'd3), "R6"); idle(LOCK_N + 2, "R6");
        // R7: bypass request while locked, repeat in bypass
        step(1, 2'd0, 32'd4, "R7"); idle(BYP_N + 2, "R7");
        step(1, 2'd0, 32'd4, "R7"); idle(2, "R7");
        // R8: writes during entering bypass
        step(1, 2'd0, 32'd7, "R8"); idle(LOCK_N + 2, "R8");
        step(1, 2'd0, 32'd4, "R8"); idle(1, "R8");
        step(1, 2'd0, 32'd7, "R8");
        step(1, 2'd1, cfgw(1'b0, 11'd20, 7'd4), "R8"); idle(BYP_N + LOCK_N + 4, "R9");
        // R10: other codes while locked
        step(1, 2'd0, 32'd0, "R10"); idle(3, "R10");
        step(1, 2'd0, 32'd5, "R10"); idle(3, "R10");
        // R4/R6: multiplier 0 while locked drops to bypass
        step(1, 2'd1, cfgw(1'b0, 11'd0, 7'd4), "R6"); idle(4, "R6");
        step(1, 2'd0, 32'd7, "R4"); idle(4, "R4");
        step(1, 2'd1, cfgw(1'b0, 11'd2, 7'd127), "R3"); idle(LOCK_N + 4, "R9");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule